// File: doc/BRIEF.md
# Fractional Clock Divider

This block derives a clock-enable pulse stream from its input clock. A 10-bit accumulator, `result_o`, works in one of two modes chosen by a 2-bit mode field. In reload mode it counts up by one each cycle. When it reaches the top value it produces a pulse and restarts from the programmed step value. The result is an integer division of the input rate. In adder mode it adds the step value every cycle and produces a pulse on each carry out of the 10-bit sum. The average rate is then step/1024 of the input.

The output is a registered enable, one input cycle wide per overflow, meant to qualify logic that runs on the same input clock. It is not a gated clock. Mode and step are sampled directly on every edge. A change therefore acts on the next edge.

Top module: `fractional_clk_div`

## Requirements
- R1: Mode encoding is 2'b01 = reload, 2'b10 = adder, and 2'b00 or 2'b11 = off. While off, `result_o` keeps its value and `pulse_o` stays low.
- R2: On the first edge in reload mode after any other mode, `result_o` is loaded with `step_i` and `pulse_o` is low.
- R3: In reload mode, when `result_o` is below 1023, each edge increments `result_o` by one with `pulse_o` low.
- R4: In reload mode, an edge that sees `result_o` = 1023 reloads `step_i` and raises `pulse_o` for that one cycle only. The pulse rate is therefore f_in/(1024-step).
- R5: In adder mode, each edge sets `result_o` to (`result_o` + `step_i`) mod 1024, and `pulse_o` to the carry of that sum.
- R6: In adder mode with a constant step, every 1024 consecutive edges give exactly step pulses. A step of 0 gives none.
- R7: After reset `result_o` is 0 and `pulse_o` is 0.
- R8: A new `step_i` value takes effect at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Operating mode (see R1) |
| step_i | input | 10 | Step / reload value |
| pulse_o | output | 1 | Registered enable pulse |
| result_o | output | 10 | Accumulator value |

## Verification
The hardest case to reach is the reload mode's edge at 1023. There the pulse and the reload of the step value must coincide and last exactly one cycle. The stimulus gets there quickly by entering reload mode with a step just below the top, so only a few increments are needed. The fractional rate in adder mode is checked by counting pulses over whole 1024-cycle windows. Over such a window the carry count must equal the step exactly, whatever the accumulator held at the start.

// File: rtl/fdiv_pkg.sv
package fdiv_pkg;
  typedef enum logic [1:0] {
    FD_OFF     = 2'b00,
    FD_RELOAD  = 2'b01,
    FD_ADDER   = 2'b10,
    FD_OFF_ALT = 2'b11
  } fd_mode_e;
endpackage

// File: rtl/fdiv_ctrl.sv
module fdiv_ctrl
  import fdiv_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] mode_i,
  output logic       reload_en_o,
  output logic       adder_en_o,
  output logic       reload_entry_o
);
  logic was_reload_q;

  assign reload_en_o    = (fd_mode_e'(mode_i) == FD_RELOAD);
  assign adder_en_o     = (fd_mode_e'(mode_i) == FD_ADDER);
  assign reload_entry_o = reload_en_o && !was_reload_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) was_reload_q <= 1'b0;
    else         was_reload_q <= reload_en_o;
  end
endmodule

// File: rtl/fdiv_accum.sv
module fdiv_accum #(
  parameter int WIDTH = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] step_i,
  input  logic             reload_en_i,
  input  logic             adder_en_i,
  input  logic             reload_entry_i,
  output logic [WIDTH-1:0] result_o,
  output logic             pulse_o
);
  localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};

  logic [WIDTH-1:0] result_q, result_d, addend;
  logic [WIDTH:0]   sum;
  logic             pulse_q, pulse_d;

  assign addend = adder_en_i ? step_i : WIDTH'(1);
  assign sum    = {1'b0, result_q} + {1'b0, addend};

  always_comb begin
    result_d = result_q;
    pulse_d  = 1'b0;
    if (reload_entry_i) begin
      result_d = step_i;
    end else if (reload_en_i) begin
      if (result_q == TOP) begin
        result_d = step_i;
        pulse_d  = 1'b1;
      end else begin
        result_d = sum[WIDTH-1:0];
      end
    end else if (adder_en_i) begin
      result_d = sum[WIDTH-1:0];
      pulse_d  = sum[WIDTH];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_q <= '0;
      pulse_q  <= 1'b0;
    end else begin
      result_q <= result_d;
      pulse_q  <= pulse_d;
    end
  end

  assign result_o = result_q;
  assign pulse_o  = pulse_q;
endmodule

// File: rtl/fractional_clk_div.sv
module fractional_clk_div #(
  parameter int WIDTH = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       mode_i,
  input  logic [WIDTH-1:0] step_i,
  output logic             pulse_o,
  output logic [WIDTH-1:0] result_o
);
  logic reload_en, adder_en, reload_entry;

  fdiv_ctrl u_ctrl (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .mode_i         (mode_i),
    .reload_en_o    (reload_en),
    .adder_en_o     (adder_en),
    .reload_entry_o (reload_entry)
  );

  fdiv_accum #(.WIDTH(WIDTH)) u_accum (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .step_i         (step_i),
    .reload_en_i    (reload_en),
    .adder_en_i     (adder_en),
    .reload_entry_i (reload_entry),
    .result_o       (result_o),
    .pulse_o        (pulse_o)
  );
endmodule

// File: rtl/fdiv_checker.sv
module fdiv_checker #(
  parameter int WIDTH = 10
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [1:0]       mode_i,
  input logic [WIDTH-1:0] step_i,
  input logic             pulse_o,
  input logic [WIDTH-1:0] result_o
);
  logic in_reload_q;
  wire  is_reload = (mode_i == 2'b01);
  wire  is_adder  = (mode_i == 2'b10);
  wire  is_off    = (mode_i == 2'b00) || (mode_i == 2'b11);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) in_reload_q <= 1'b0;
    else         in_reload_q <= is_reload;
  end

  assert_off_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_off |=> ($stable(result_o) && !pulse_o));

  assert_reload_entry_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_reload && !in_reload_q) |=> (result_o == $past(step_i) && !pulse_o));

  assert_reload_count_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_reload && in_reload_q && result_o != {WIDTH{1'b1}})
      |=> (result_o == $past(result_o) + 1'b1 && !pulse_o));

  assert_reload_wrap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_reload && in_reload_q && result_o == {WIDTH{1'b1}})
      |=> (pulse_o && result_o == $past(step_i)));

  assert_adder_sum_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_adder |=> ({pulse_o, result_o} == {1'b0, $past(result_o)} + {1'b0, $past(step_i)}));
endmodule

bind fractional_clk_div fdiv_checker #(.WIDTH(WIDTH)) u_fdiv_checker (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .mode_i   (mode_i),
  .step_i   (step_i),
  .pulse_o  (pulse_o),
  .result_o (result_o)
);

// File: tb/tb_fractional_clk_div.sv
module tb_fractional_clk_div;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 10;
  // mode, step, counted edges, expected pulses
  localparam int V_MODE [NV] = '{1, 1, 1, 1, 2, 2, 2, 2, 2, 1};
  localparam int V_STEP [NV] = '{1000, 1023, 0, 512, 0, 1, 512, 1023, 300, 768};
  localparam int V_LEN  [NV] = '{96, 10, 1024, 1024, 1024, 1024, 1024, 1024, 2048, 768};
  localparam int V_EXP  [NV] = '{4, 10, 1, 2, 0, 1, 512, 1023, 600, 3};

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode = 2'b00;
  logic [9:0] step = '0;
  logic       pulse;
  logic [9:0] result;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fractional_clk_div dut (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .step_i(step),
    .pulse_o(pulse), .result_o(result)
  );

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // drive at negedge, one posedge, sample at next negedge
  task automatic step_cycle();
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (300000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      finish_run();
    end
  end

  initial begin
    int r0;
    int cnt;
    @(negedge clk);
    check("R7 result", result, 0);
    check("R7 pulse", pulse, 0);
    rst_n = 1'b1;

    // rate table (R4, R6)
    for (int v = 0; v < NV; v++) begin
      mode = 2'b00; step_cycle();
      mode = 2'(V_MODE[v]); step = 10'(V_STEP[v]); step_cycle();
      cnt = 0;
      for (int c = 0; c < V_LEN[v]; c++) begin
        step_cycle();
        cnt += int'(pulse);
      end
      check(V_MODE[v] == 1 ? "R4 reload rate" : "R6 adder rate", cnt, V_EXP[v]);
    end

    // R1: off modes hold result, no pulses
    mode = 2'b10; step = 10'd333; step_cycle();
    r0 = result; cnt = 0;
    mode = 2'b00;
    for (int c = 0; c < 5; c++) begin step_cycle(); cnt += int'(pulse); end
    check("R1 mode 00 hold", result, r0);
    check("R1 mode 00 no pulse", cnt, 0);
    mode = 2'b11; cnt = 0;
    for (int c = 0; c < 5; c++) begin step_cycle(); cnt += int'(pulse); end
    check("R1 mode 11 hold", result, r0);
    check("R1 mode 11 no pulse", cnt, 0);

    // R2/R3: reload entry and increment
    mode = 2'b01; step = 10'd5; step_cycle();
    check("R2 entry load", result, 5);
    check("R2 entry pulse", pulse, 0);
    step_cycle();
    check("R3 increment", result, 6);
    check("R3 no pulse", pulse, 0);

    // R4: wrap at 1023 with one-cycle pulse
    mode = 2'b00; step_cycle();
    mode = 2'b01; step = 10'd1020; step_cycle();
    step_cycle(); step_cycle(); step_cycle();
    check("R3 reach top", result, 1023);
    check("R4 no pulse before wrap", pulse, 0);
    step_cycle();
    check("R4 wrap pulse", pulse, 1);
    check("R4 wrap reload", result, 1020);
    step_cycle();
    check("R4 pulse one cycle", pulse, 0);
    check("R4 count resumes", result, 1021);

    // R5/R8: adder arithmetic and step change
    rst_n = 1'b0; step_cycle();
    check("R7 reset again", result, 0);
    rst_n = 1'b1;
    mode = 2'b10; step = 10'd700; step_cycle();
    check("R5 first sum", result, 700);
    check("R5 no carry", pulse, 0);
    step_cycle();
    check("R5 wrapped sum", result, 376);
    check("R5 carry pulse", pulse, 1);
    step = 10'd10; step_cycle();
    check("R8 new step used", result, 386);
    check("R8 no carry", pulse, 0);

    // R2: switch from adder to reload loads step
    mode = 2'b01; step = 10'd9; step_cycle();
    check("R2 adder->reload load", result, 9);
    check("R2 adder->reload pulse", pulse, 0);

    done = 1'b1;
    finish_run();
  end
endmodule